// File: doc/BRIEF.md
# EDO DRAM Cycle Decoder Front End

This block sits on the memory side of an 8-bit extended-data-out DRAM interface. A fast clock samples the active-low strobes (row strobe, column strobe, write strobe, output gate) and the shared row/column address pins. The block finds strobe edges by comparing each sample with the one before it. From the order in which those edges arrive it names the kind of memory cycle in progress. It then writes to or reads from a small on-chip storage array and controls the enable of a tri-state data driver.

The row address is captured when the row strobe falls. The column address is captured on every column strobe fall that happens while the row strobe is low, so page-mode bursts work. The array index is formed with the row as the upper bits and the column as the lower bits. Read data stays on the output after the column strobe rises. The driver only lets go once both strobes are high again, whichever of them rose last. It also lets go when the output gate is released or when a write strobe begins. Every output is registered, so it reflects inputs sampled one clock earlier. Analog timing limits are not checked.

Top module: `edo_cycle_decoder`

## Requirements
- R1: While the row and column strobes are both high, the output enable is low one clock later and the cycle code reads 0 (idle).
- R2: A row strobe fall with the column strobe already low gives cycle code 6. A row strobe fall with the column strobe high gives code 5 until a column strobe fall reclassifies it. During a code 6 or code 5 period, the output stays off and no array location is written, whatever the write strobe and output gate do.
- R3: If the write strobe is low when the column strobe falls, the cycle code is 2 (early write) and the data input is stored at the latched row and the column on the pins at that edge. The output stays off for the rest of that column access, even with the output gate low.
- R4: If the write strobe falls while the column strobe is low in a cycle coded 1 (read), the data input is stored at the latched row and column. The code becomes 4 (read-modify-write) if the output was driven since that column strobe fall, and 3 (delayed write) otherwise. The output is off while the write strobe is low.
- R5: A column strobe fall with the write strobe high gives cycle code 1 and fetches the addressed data. The output is enabled one clock after any sample where the output gate is low and the write strobe is high, and disabled one clock after the output gate is high.
- R6: After the column strobe rises with the row strobe still low, or the row strobe rises with the column strobe still low, the read data and enable are held. The enable drops one clock after both strobes are high.
- R7: Each column strobe fall within one row strobe low period selects a new column with the row latched at the row strobe fall.
- R8: Array index = {row, column}, row in the upper bits; distinct row/column pairs reach distinct locations even when their bit patterns are swapped.
- R9: After synchronous reset the cycle code is 0 and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output gate, active low |
| addr | input | PIN_W | Shared row/column address pins |
| din | input | DATA_W | Write data from the pins |
| dout | output | DATA_W | Read data toward the pin driver |
| dout_en | output | 1 | Driver enable; low means high impedance |
| cyc_kind | output | 3 | Cycle code: 0 idle, 1 read, 2 early write, 3 delayed write, 4 read-modify-write, 5 row-only refresh, 6 column-first refresh |

## Verification
The strobe sequences are chosen so that each pair of similar cycle types is split by a single change in edge order. A write strobe that is low before the column strobe falls versus one that falls after it separates early from delayed writes. An output gate that was or was not asserted before the write strobe fell separates read-modify-write from delayed write. A column strobe that falls before or after the row strobe separates the two refresh types. Read sequences release the row and column strobes in both orders and toggle the output gate during the hold. Paired writes to swapped row/column patterns and page bursts over several columns show where data lands, and a read after each refresh shows the array was left untouched.

// File: rtl/edo_dec_pkg.sv
package edo_dec_pkg;

    typedef enum logic [2:0] {
        CYC_IDLE     = 3'd0,
        CYC_READ     = 3'd1,
        CYC_EARLY_WR = 3'd2,
        CYC_LATE_WR  = 3'd3,
        CYC_RMW      = 3'd4,
        CYC_ROW_RFSH = 3'd5,
        CYC_CBR_RFSH = 3'd6
    } cyc_kind_e;

    // Sampled strobe levels, all active low.
    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

    // Falling-edge events seen between two consecutive samples.
    typedef struct packed {
        logic ras_fall;
        logic cas_fall;
        logic we_fall;
    } strobe_ev_t;

    localparam strobe_t STROBE_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

    function automatic strobe_ev_t find_edges(strobe_t prev, strobe_t now);
        strobe_ev_t ev;
        ev.ras_fall = prev.ras_n & ~now.ras_n;
        ev.cas_fall = prev.cas_n & ~now.cas_n;
        ev.we_fall  = prev.we_n  & ~now.we_n;
        return ev;
    endfunction

endpackage

// File: rtl/strobe_sampler.sv
module strobe_sampler
    import edo_dec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  strobe_t    pins,
    output strobe_ev_t ev
);

    strobe_t last_q;

    always_ff @(posedge clk) begin
        if (rst) last_q <= STROBE_IDLE;
        else     last_q <= pins;
    end

    assign ev = find_edges(last_q, pins);

endmodule

// File: rtl/cycle_classifier.sv
module cycle_classifier
    import edo_dec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  strobe_t    pins,
    input  strobe_ev_t ev,
    output cyc_kind_e  kind,
    output logic       drive_en,
    output logic       rd_stb,
    output logic       early_wr,
    output logic       late_wr
);

    cyc_kind_e kind_q, kind_d;
    logic      live_q, live_d;   // read data owned by the driver
    logic      seen_q, seen_d;   // driver was on since the last column fall
    logic      drive_q, drive_d;
    logic      seen_now;

    assign seen_now = seen_q | drive_q;

    always_comb begin
        kind_d   = kind_q;
        live_d   = live_q;
        seen_d   = seen_now;
        rd_stb   = 1'b0;
        early_wr = 1'b0;
        late_wr  = 1'b0;

        if (ev.ras_fall) begin
            kind_d = pins.cas_n ? CYC_ROW_RFSH : CYC_CBR_RFSH;
            live_d = 1'b0;
            seen_d = 1'b0;
        end else if (!pins.ras_n && ev.cas_fall && kind_q != CYC_CBR_RFSH) begin
            seen_d = 1'b0;
            if (!pins.we_n) begin
                kind_d   = CYC_EARLY_WR;
                early_wr = 1'b1;
                live_d   = 1'b0;
            end else begin
                kind_d = CYC_READ;
                rd_stb = 1'b1;
                live_d = 1'b1;
            end
        end else if (!pins.ras_n && !pins.cas_n && ev.we_fall && kind_q == CYC_READ) begin
            kind_d  = seen_now ? CYC_RMW : CYC_LATE_WR;
            late_wr = 1'b1;
            live_d  = 1'b0;
        end

        if (pins.ras_n && pins.cas_n) live_d = 1'b0;
        if (pins.ras_n && !live_d)    kind_d = CYC_IDLE;

        drive_d = live_d & ~pins.oe_n & pins.we_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q  <= CYC_IDLE;
            live_q  <= 1'b0;
            seen_q  <= 1'b0;
            drive_q <= 1'b0;
        end else begin
            kind_q  <= kind_d;
            live_q  <= live_d;
            seen_q  <= seen_d;
            drive_q <= drive_d;
        end
    end

    assign kind     = kind_q;
    assign drive_en = drive_q;

endmodule

// File: rtl/cell_array.sv
module cell_array #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_data;
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/edo_cycle_decoder.sv
module edo_cycle_decoder
    import edo_dec_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 3,
    parameter int DATA_W = 8,
    parameter int PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [PIN_W-1:0]  addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic [2:0]        cyc_kind
);

    localparam int ADDR_W = ROW_W + COL_W;

    strobe_t     pins;
    strobe_ev_t  ev;
    cyc_kind_e   kind;
    logic        drive_en, rd_stb, early_wr, late_wr;

    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, dout_q;

    assign pins = {ras_n, cas_n, we_n, oe_n};

    strobe_sampler u_sampler (
        .clk  (clk),
        .rst  (rst),
        .pins (pins),
        .ev   (ev)
    );

    cycle_classifier u_class (
        .clk      (clk),
        .rst      (rst),
        .pins     (pins),
        .ev       (ev),
        .kind     (kind),
        .drive_en (drive_en),
        .rd_stb   (rd_stb),
        .early_wr (early_wr),
        .late_wr  (late_wr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q  <= '0;
            col_q  <= '0;
            dout_q <= '0;
        end else begin
            if (ev.ras_fall)            row_q  <= addr[ROW_W-1:0];
            if (ev.cas_fall && !ras_n)  col_q  <= addr[COL_W-1:0];
            if (rd_stb)                 dout_q <= rd_data;
        end
    end

    // Row forms the upper index bits, column the lower ones.
    assign rd_addr = {row_q, addr[COL_W-1:0]};
    assign wr_addr = early_wr ? rd_addr : {row_q, col_q};

    cell_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cells (
        .clk     (clk),
        .wr_en   (early_wr | late_wr),
        .wr_addr (wr_addr),
        .wr_data (din),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign dout     = dout_q;
    assign dout_en  = drive_en;
    assign cyc_kind = kind;

endmodule

// File: rtl/edo_dec_checker.sv
module edo_dec_checker
    import edo_dec_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic       oe_n,
    input logic       dout_en,
    input logic [2:0] cyc_kind
);

    p_standby_off_r1: assert property (@(posedge clk) disable iff (rst)
        (ras_n && cas_n) |=> (!dout_en && cyc_kind == CYC_IDLE));

    p_cbr_detect_r2: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && $past(ras_n) && !cas_n) |=> (cyc_kind == CYC_CBR_RFSH));

    p_refresh_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (cyc_kind == CYC_CBR_RFSH || cyc_kind == CYC_ROW_RFSH) |-> !dout_en);

    p_early_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (cyc_kind == CYC_EARLY_WR) |-> !dout_en);

    p_write_strobe_off_r4: assert property (@(posedge clk) disable iff (rst)
        (!we_n) |=> !dout_en);

    p_gate_off_r5: assert property (@(posedge clk) disable iff (rst)
        oe_n |=> !dout_en);

endmodule

bind edo_cycle_decoder edo_dec_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .dout_en  (dout_en),
    .cyc_kind (cyc_kind)
);

// File: tb/edo_cycle_decoder_test.sv
module edo_cycle_decoder_test;

    localparam int ROW_W = 4, COL_W = 3, DATA_W = 8, PIN_W = 4;
    localparam int K_IDLE = 0, K_READ = 1, K_EWR = 2, K_DWR = 3, K_RMW = 4, K_ROR = 5, K_CBR = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [PIN_W-1:0]  addr = '0;
    logic [DATA_W-1:0] din  = '0;
    logic [DATA_W-1:0] dout;
    logic              dout_en;
    logic [2:0]        cyc_kind;

    edo_cycle_decoder #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .PIN_W(PIN_W)) uut (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .cyc_kind(cyc_kind)
    );

    always #10 clk = ~clk;

    typedef struct {
        int          due;
        string       tag;
        int          kind;
        bit          en;
        logic [7:0]  d;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares scoreboard items when their cycle comes up.
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (cyc_kind !== 3'(e.kind) || dout_en !== e.en || (e.en && dout !== e.d)) begin
                    fails++;
                    $display("FAIL %s: kind=%0d en=%0b dout=%h expected kind=%0d en=%0b dout=%h",
                             e.tag, cyc_kind, dout_en, dout, e.kind, e.en, e.d);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): run did not end, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic tick(input logic r, input logic c, input logic w, input logic o,
                        input logic [PIN_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a; din = d;
    endtask

    task automatic expect_out(input string tag, input int k, input bit en, input logic [7:0] d);
        exp_t e;
        e.due = cyc + 1; e.tag = tag; e.kind = k; e.en = en; e.d = d;
        sb.push_back(e);
    endtask

    task automatic early_write(input logic [PIN_W-1:0] row, input logic [PIN_W-1:0] col,
                               input logic [7:0] d, input string tag);
        tick(0, 1, 1, 1, row, 8'h00);
        tick(0, 1, 0, 1, row, 8'h00);
        tick(0, 0, 0, 0, col, d);   expect_out(tag, K_EWR, 0, 8'h00);
        tick(0, 0, 1, 0, col, d);   expect_out(tag, K_EWR, 0, 8'h00);
        tick(1, 1, 1, 1, 0, 8'h00); expect_out("R1", K_IDLE, 0, 8'h00);
    endtask

    task automatic read_one(input logic [PIN_W-1:0] row, input logic [PIN_W-1:0] col,
                            input logic [7:0] d, input string tag);
        tick(0, 1, 1, 1, row, 8'h00); expect_out("R2", K_ROR, 0, 8'h00);
        tick(0, 0, 1, 0, col, 8'h00); expect_out(tag, K_READ, 1, d);
        tick(1, 1, 1, 1, 0, 8'h00);   expect_out("R1", K_IDLE, 0, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        tick(1, 1, 1, 1, 0, 8'h00); expect_out("R9", K_IDLE, 0, 8'h00);

        // R3 early write; R8 swapped row/column patterns
        early_write(4'd3, 4'd2, 8'hA5, "R3");
        early_write(4'd2, 4'd3, 8'h3C, "R8");
        read_one(4'd3, 4'd2, 8'hA5, "R8");
        read_one(4'd2, 4'd3, 8'h3C, "R8");

        // R5 output gate, R6 hold after column strobe rises first
        tick(0, 1, 1, 1, 4'd3, 8'h00); expect_out("R2", K_ROR, 0, 8'h00);
        tick(0, 0, 1, 0, 4'd2, 8'h00); expect_out("R5", K_READ, 1, 8'hA5);
        tick(0, 1, 1, 0, 4'd2, 8'h00); expect_out("R6", K_READ, 1, 8'hA5);
        tick(0, 1, 1, 1, 4'd2, 8'h00); expect_out("R5", K_READ, 0, 8'h00);
        tick(0, 1, 1, 0, 4'd2, 8'h00); expect_out("R6", K_READ, 1, 8'hA5);
        tick(1, 1, 1, 0, 4'd0, 8'h00); expect_out("R6", K_IDLE, 0, 8'h00);

        // R6 hold when the row strobe rises first
        tick(0, 1, 1, 1, 4'd2, 8'h00);
        tick(0, 0, 1, 0, 4'd3, 8'h00); expect_out("R5", K_READ, 1, 8'h3C);
        tick(1, 0, 1, 0, 4'd3, 8'h00); expect_out("R6", K_READ, 1, 8'h3C);
        tick(1, 1, 1, 0, 4'd0, 8'h00); expect_out("R6", K_IDLE, 0, 8'h00);

        // R7 page-mode writes then page-mode reads in row 5
        tick(0, 1, 1, 1, 4'd5, 8'h00);
        tick(0, 0, 0, 1, 4'd0, 8'h11); expect_out("R7", K_EWR, 0, 8'h00);
        tick(0, 1, 1, 1, 4'd0, 8'h00);
        tick(0, 0, 0, 1, 4'd1, 8'h22); expect_out("R7", K_EWR, 0, 8'h00);
        tick(0, 1, 1, 1, 4'd1, 8'h00);
        tick(0, 0, 0, 1, 4'd7, 8'h33); expect_out("R7", K_EWR, 0, 8'h00);
        tick(1, 1, 1, 1, 4'd0, 8'h00);
        tick(0, 1, 1, 0, 4'd5, 8'h00); expect_out("R2", K_ROR, 0, 8'h00);
        tick(0, 0, 1, 0, 4'd0, 8'h00); expect_out("R7", K_READ, 1, 8'h11);
        tick(0, 1, 1, 0, 4'd0, 8'h00); expect_out("R6", K_READ, 1, 8'h11);
        tick(0, 0, 1, 0, 4'd1, 8'h00); expect_out("R7", K_READ, 1, 8'h22);
        tick(0, 1, 1, 0, 4'd1, 8'h00);
        tick(0, 0, 1, 0, 4'd7, 8'h00); expect_out("R7", K_READ, 1, 8'h33);
        tick(1, 1, 1, 1, 4'd0, 8'h00); expect_out("R1", K_IDLE, 0, 8'h00);

        // R4 delayed write: output gate never asserted
        tick(0, 1, 1, 1, 4'd6, 8'h00);
        tick(0, 0, 1, 1, 4'd4, 8'h00); expect_out("R4", K_READ, 0, 8'h00);
        tick(0, 0, 0, 1, 4'd4, 8'h77); expect_out("R4", K_DWR, 0, 8'h00);
        tick(0, 0, 1, 1, 4'd4, 8'h00);
        tick(1, 1, 1, 1, 4'd0, 8'h00);
        read_one(4'd6, 4'd4, 8'h77, "R4");

        // R4 read-modify-write: data driven, gate released, then write
        tick(0, 1, 1, 1, 4'd6, 8'h00);
        tick(0, 0, 1, 0, 4'd4, 8'h00); expect_out("R4", K_READ, 1, 8'h77);
        tick(0, 0, 1, 1, 4'd4, 8'h00); expect_out("R5", K_READ, 0, 8'h00);
        tick(0, 0, 0, 1, 4'd4, 8'h99); expect_out("R4", K_RMW, 0, 8'h00);
        tick(0, 0, 1, 1, 4'd4, 8'h00);
        tick(1, 1, 1, 1, 4'd0, 8'h00);
        read_one(4'd6, 4'd4, 8'h99, "R4");

        // R2 column-first refresh: no drive, no write
        tick(1, 0, 1, 1, 4'd6, 8'h00); expect_out("R2", K_IDLE, 0, 8'h00);
        tick(0, 0, 1, 0, 4'd6, 8'h00); expect_out("R2", K_CBR, 0, 8'h00);
        tick(0, 0, 0, 0, 4'd4, 8'hEE); expect_out("R2", K_CBR, 0, 8'h00);
        tick(0, 0, 1, 0, 4'd4, 8'h00); expect_out("R2", K_CBR, 0, 8'h00);
        tick(1, 1, 1, 1, 4'd0, 8'h00); expect_out("R1", K_IDLE, 0, 8'h00);
        read_one(4'd6, 4'd4, 8'h99, "R2");

        // R2 row-only refresh with gate and write strobe active
        tick(0, 1, 1, 0, 4'd9, 8'h00); expect_out("R2", K_ROR, 0, 8'h00);
        tick(0, 1, 0, 0, 4'd9, 8'h55); expect_out("R2", K_ROR, 0, 8'h00);
        tick(1, 1, 1, 1, 4'd0, 8'h00); expect_out("R1", K_IDLE, 0, 8'h00);
        read_one(4'd3, 4'd2, 8'hA5, "R2");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule